// File: doc/BRIEF.md
# FM0 Downlink Frame Transmitter

The block turns one downlink frame for a short-range roadside beacon link into a single FM0-coded line. Bytes for the link address, the control fields and the payload arrive on a valid/ready stream, and a marker flags the final byte of the frame. Accepting the first byte starts the frame. The line then carries a run of preamble ones, an opening flag octet, the body with zero-insertion, a 16-bit check field and a closing flag octet. When the frame is done the line falls back to a steady low level.

All cell timing comes from a clock-enable pulse at twice the bit rate, one pulse per half bit cell. Running the enable at 1 MHz gives 500 kbit/s. A test input can invert one chosen body bit on the line while the check field is still computed from the true data. A receiver can then be shown to reject the frame.

Top module: `fm0_frame_tx`

## Requirements
- R1: After reset, and between frames, `line_out` is low and does not toggle, and `s_ready` is high. A synchronous reset during a frame abandons it: one clock later `line_out` is low and `s_ready` is high.
- R2: The line changes only on clock cycles where `half_en` is high. Every bit cell lasts two `half_en` pulses and starts with a level change. A 0 bit also changes level at mid-cell. A 1 bit holds its level for the whole cell.
- R3: The first half cell after the first byte is accepted starts `PRE_BITS` cells of ones (16 by default). The first of these cells drives the line high.
- R4: The preamble is followed by the flag octet 0x7E (bit pattern 0,1,1,1,1,1,1,0). The same octet comes after the check field. Neither flag is zero-stuffed.
- R5: Body bytes go out in the order they were accepted, each least significant bit first. The body ends with the byte that was presented with `s_last` high.
- R6: In the body and in the check field, a 0 cell is inserted after every five 1 cells in a row. This includes a run that ends with the last check bit. The count of ones starts again at the beginning of the body.
- R7: The check field is the bitwise complement of a 16-bit CRC with polynomial 0x1021 and preset 0xFFFF. The CRC register shifts left, and its feedback is the register MSB XOR the data bit. It is fed the unstuffed body bits in send order, and it is sent MSB first.
- R8: `s_ready` is low from the preamble until the last opening-flag cell begins. It is low again from acceptance of the last byte until the half cell after the closing flag, when it returns high.
- R9: When `err_en` is high as the first byte is accepted, body data bit number `err_idx` (0 = LSB of the first byte, stuff bits not counted) is inverted on the line. Stuffing follows the inverted bit, and the check field is still computed from the true data. An index at or beyond the body length changes nothing.
- R10: After the closing flag's last cell, the line is driven low at the next half-cell pulse and stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_en | input | 1 | Clock enable, one pulse per half bit cell |
| s_data | input | 8 | Frame byte |
| s_valid | input | 1 | Byte valid |
| s_last | input | 1 | Byte is the last of the frame |
| s_ready | output | 1 | Block accepts a byte this cycle |
| err_en | input | 1 | Arm bit inversion for the frame being started |
| err_idx | input | IDX_W | Body data bit to invert |
| line_out | output | 1 | FM0-coded line |

## Verification
Several byte patterns test different parts of the logic:
- A single zero byte gives long runs of mid-cell transitions and no stuffing.
- All-ones bytes force repeated zero insertion.
- Bytes equal to the flag octet show that body data cannot close the frame early.
- A mixed eight-byte frame exercises the byte hand-over and the check arithmetic.

Each captured waveform is compared half cell by half cell against a model built from the requirements. Injection frames with an index inside the body must differ from the clean frame. An index beyond the body must leave the frame unchanged, which separates the check path from the transmit path. A reset in mid-preamble shows that a frame is abandoned cleanly.

// File: rtl/fm0_frame_tx.sv
module fm0_frame_tx #(
  parameter int PRE_BITS = 16,
  parameter int IDX_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_en,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  input  logic             s_last,
  output logic             s_ready,
  input  logic             err_en,
  input  logic [IDX_W-1:0] err_idx,
  output logic             line_out
);

  localparam int CNT_W = ($clog2(PRE_BITS + 1) > 5) ? $clog2(PRE_BITS + 1) : 5;
  localparam logic [7:0]  FLAG = 8'h7E;
  localparam logic [15:0] POLY = 16'h1021;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SFLG, S_BODY, S_FCS, S_EFLG, S_DONE} st_t;

  st_t              st;
  logic             ph, line, cur;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       ones, bidx;
  logic [15:0]      crc;
  logic [7:0]       sh, hold;
  logic             blast, hv, hlast, got_last, inj_on;
  logic [IDX_W-1:0] inj_at, dcnt;

  logic        take, do_stuff, raw, tbit, fcs_end, nbit;
  logic [15:0] crc_nx;

  assign s_ready  = !hv && !got_last;
  assign take     = s_valid && s_ready;
  assign line_out = line;
  assign do_stuff = (st == S_BODY || st == S_FCS) && ones == 3'd5;
  assign raw      = sh[bidx];
  assign tbit     = raw ^ (inj_on && dcnt == inj_at);
  assign fcs_end  = cnt[4];
  assign crc_nx   = {crc[14:0], 1'b0} ^ ((crc[15] ^ raw) ? POLY : 16'h0000);

  always_comb begin
    case (st)
      S_PRE:          nbit = 1'b1;
      S_SFLG, S_EFLG: nbit = FLAG[cnt[2:0]];
      S_BODY:         nbit = do_stuff ? 1'b0 : tbit;
      S_FCS:          nbit = do_stuff ? 1'b0 : (fcs_end ? FLAG[0] : ~crc[~cnt[3:0]]);
      default:        nbit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; line <= 1'b0; cur <= 1'b0;
      cnt <= '0; ones <= '0; bidx <= '0; crc <= 16'hFFFF;
      sh <= '0; hold <= '0; blast <= 1'b0; hv <= 1'b0; hlast <= 1'b0;
      got_last <= 1'b0; inj_on <= 1'b0; inj_at <= '0; dcnt <= '0;
    end else begin
      if (take) begin
        hold <= s_data; hv <= 1'b1; hlast <= s_last;
        if (s_last) got_last <= 1'b1;
      end
      if (st == S_IDLE) begin
        if (take) begin
          st <= S_PRE; cnt <= '0; ph <= 1'b0;
          inj_on <= err_en; inj_at <= err_idx;
        end
      end else if (half_en) begin
        ph <= ~ph;
        if (ph) begin
          if (!cur) line <= ~line;
        end else if (st == S_DONE) begin
          line <= 1'b0; st <= S_IDLE; got_last <= 1'b0; ph <= 1'b0;
        end else begin
          line <= ~line;
          cur  <= nbit;
          case (st)
            S_PRE:
              if (cnt == CNT_W'(PRE_BITS - 1)) begin st <= S_SFLG; cnt <= '0; end
              else cnt <= cnt + CNT_W'(1);
            S_SFLG:
              if (cnt == CNT_W'(7)) begin
                st <= S_BODY; sh <= hold; blast <= hlast; hv <= 1'b0;
                bidx <= '0; ones <= '0; crc <= 16'hFFFF; dcnt <= '0;
              end else cnt <= cnt + CNT_W'(1);
            S_BODY:
              if (do_stuff) ones <= '0;
              else begin
                ones <= tbit ? ones + 3'd1 : 3'd0;
                crc  <= crc_nx;
                dcnt <= dcnt + IDX_W'(1);
                if (bidx == 3'd7) begin
                  if (blast) begin
                    st <= S_FCS; cnt <= '0;
                  end else if (hv) begin
                    sh <= hold; blast <= hlast; hv <= 1'b0; bidx <= '0;
                  end else begin
                    st <= S_FCS; cnt <= '0; got_last <= 1'b1;
                  end
                end else bidx <= bidx + 3'd1;
              end
            S_FCS:
              if (do_stuff) ones <= '0;
              else if (fcs_end) begin st <= S_EFLG; cnt <= CNT_W'(1); end
              else begin
                ones <= nbit ? ones + 3'd1 : 3'd0;
                cnt  <= cnt + CNT_W'(1);
              end
            S_EFLG:
              if (cnt == CNT_W'(7)) st <= S_DONE;
              else cnt <= cnt + CNT_W'(1);
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

endmodule

module fm0_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       half_en,
  input logic       line_out,
  input logic       s_ready,
  input logic [2:0] st,
  input logic       ph,
  input logic [2:0] ones
);
  localparam logic [2:0] C_IDLE = 3'd0, C_PRE = 3'd1, C_SFLG = 3'd2,
                         C_FCS = 3'd4, C_EFLG = 3'd5, C_DONE = 3'd6;
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (st == C_IDLE) |-> !line_out);
  assert_quiet_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !half_en |=> $stable(line_out));
  assert_cell_edge_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (half_en && !ph && st != C_IDLE && st != C_DONE) |=> (line_out != $past(line_out)));
  assert_run_limit_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ones <= 3'd5);
  assert_ready_head_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (st == C_PRE || st == C_SFLG) |-> !s_ready);
  assert_ready_tail_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (st == C_FCS || st == C_EFLG || st == C_DONE) |-> !s_ready);
endmodule

bind fm0_frame_tx fm0_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .half_en(half_en), .line_out(line_out),
  .s_ready(s_ready), .st(st), .ph(ph), .ones(ones)
);

// File: tb/fm0_frame_tx_tb.sv
module fm0_frame_tx_tb;
  localparam int PRE = 16;
  localparam int IW  = 10;
  localparam int NV  = 7;
  localparam logic [76:0] VEC [0:NV-1] = '{
    {4'd1, 1'b0, 8'd0,  64'h0000000000000000},
    {4'd2, 1'b0, 8'd0,  64'h000000000000FFFF},
    {4'd4, 1'b0, 8'd0,  64'h000000007E7E7E7E},
    {4'd8, 1'b0, 8'd0,  64'h0F1E2D3C4B5A6978},
    {4'd3, 1'b1, 8'd9,  64'h0000000000FFAA55},
    {4'd2, 1'b1, 8'd40, 64'h0000000000000FF0},
    {4'd5, 1'b1, 8'd0,  64'h000000FFFFFFFFFF}
  };

  logic clk = 0, rst_n = 0, half_en = 0;
  logic [7:0] s_data = 0;
  logic s_valid = 0, s_last = 0, err_en = 0;
  logic [IW-1:0] err_idx = 0;
  logic s_ready, line_out;

  fm0_frame_tx #(.PRE_BITS(PRE), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .s_data(s_data),
    .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .err_en(err_en), .err_idx(err_idx), .line_out(line_out));

  always #5 clk = ~clk;

  bit cap [0:4095];
  bit rdy [0:4095];
  int cap_n = 0;
  bit cap_on = 0;
  bit eb [0:1023];
  bit eh [0:2047];
  bit ch [0:2047];
  int ne, nh, ones;
  int checks = 0, fails = 0;

  initial begin
    forever begin
      @(negedge clk) half_en = 1;
      @(negedge clk) half_en = 0;
      @(negedge clk);
      if (cap_on && cap_n < 4096) begin
        cap[cap_n] = line_out; rdy[cap_n] = s_ready; cap_n++;
      end
      @(negedge clk);
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic push_st(input bit b);
    eb[ne++] = b;
    if (b) ones++; else ones = 0;
    if (ones == 5) begin eb[ne++] = 1'b0; ones = 0; end
  endtask

  task automatic build(input int len, input logic [63:0] d, input bit ie, input int ii);
    logic [15:0] crc, cf;
    logic [7:0] fl;
    bit raw, fb, lvl;
    fl = 8'h7E; ne = 0;
    for (int i = 0; i < PRE; i++) eb[ne++] = 1'b1;
    for (int j = 0; j < 8; j++) eb[ne++] = fl[j];
    ones = 0; crc = 16'hFFFF;
    for (int i = 0; i < len; i++)
      for (int j = 0; j < 8; j++) begin
        raw = d[8*i+j];
        fb  = crc[15] ^ raw;
        crc = {crc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        push_st(raw ^ (ie && (8*i+j) == ii));
      end
    cf = ~crc;
    for (int k = 15; k >= 0; k--) push_st(cf[k]);
    for (int j = 0; j < 8; j++) eb[ne++] = fl[j];
    nh = 0; lvl = 0;
    for (int i = 0; i < ne; i++) begin
      lvl = !lvl; eh[nh++] = lvl;
      if (!eb[i]) lvl = !lvl;
      eh[nh++] = lvl;
    end
  endtask

  task automatic send(input int len, input logic [63:0] d);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1; s_data = d[8*i +: 8]; s_last = (i == len - 1);
      while (!s_ready) @(negedge clk);
    end
    @(negedge clk);
    s_valid = 0; s_last = 0;
  endtask

  task automatic run_frame(input int v);
    int len, ii, s, bad, diff;
    bit ie;
    logic [63:0] d;
    len = int'(VEC[v][76:73]); ie = VEC[v][72]; ii = int'(VEC[v][71:64]); d = VEC[v][63:0];
    build(len, d, 1'b0, 0);
    for (int i = 0; i < nh; i++) ch[i] = eh[i];
    build(len, d, ie, ii);
    err_en = ie; err_idx = IW'(ii);
    cap_n = 0; cap_on = 1;
    while (cap_n < 6) @(negedge clk);
    send(len, d);
    err_en = 0;
    while (cap_n < nh + 40) @(negedge clk);
    cap_on = 0;
    s = -1;
    for (int i = 0; i < 40 && s < 0; i++) if (cap[i]) s = i;
    chk(s >= 6, $sformatf("R1 idle low before frame %0d (first high half)", v), s, 6);
    if (s < 0) s = 0;
    bad = 0;
    for (int i = 0; i < 2*(PRE+8); i++) if (cap[s+i] != eh[i]) bad++;
    chk(bad == 0, $sformatf("R3 R4 preamble and opening flag, frame %0d (bad halves)", v), bad, 0);
    bad = 0;
    for (int i = 0; i < nh/2; i++) if (cap[s+2*i] == ((i == 0) ? 1'b0 : cap[s+2*i-1])) bad++;
    chk(bad == 0, $sformatf("R2 cell-start transitions, frame %0d (missing)", v), bad, 0);
    bad = 0;
    for (int i = 0; i < nh; i++) if (cap[s+i] != eh[i]) bad++;
    chk(bad == 0, $sformatf("R5 R6 R7 full frame %0d (bad halves)", v), bad, 0);
    if (ie) begin
      diff = 0;
      for (int i = 0; i < nh; i++) if (eh[i] != ch[i]) diff++;
      chk((ii < 8*len) ? (diff > 0) : (diff == 0),
          $sformatf("R9 injection at bit %0d, frame %0d (model differs)", ii, v),
          diff > 0, ii < 8*len);
    end
    bad = 0;
    for (int i = 0; i < 6; i++) if (cap[s+nh+i]) bad++;
    chk(bad == 0, $sformatf("R10 line low after closing flag, frame %0d (high halves)", v), bad, 0);
    bad = 0;
    for (int i = 0; i < 2*(PRE+7); i++) if (rdy[s+i]) bad++;
    chk(bad == 0, $sformatf("R8 ready low through preamble, frame %0d (high halves)", v), bad, 0);
    chk(!rdy[s+nh-1] && rdy[s+nh], $sformatf("R8 ready returns after closing flag, frame %0d", v),
        {rdy[s+nh-1], rdy[s+nh]}, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(line_out == 0 && s_ready == 1, "R1 reset state (line,ready)", {line_out, s_ready}, 1);
    for (int v = 0; v < NV; v++) run_frame(v);
    @(negedge clk);
    s_valid = 1; s_data = 8'h00; s_last = 1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 0; s_last = 0;
    repeat (80) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(line_out == 0 && s_ready == 1, "R1 reset mid-frame (line,ready)", {line_out, s_ready}, 1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    run_frame(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule